// File: doc/BRIEF.md
# Infrared Frame Interrupt Status Unit

This unit gathers the interrupt-relevant state of a fast infrared framed serial link and presents it as one status word, one mask word and one interrupt line. Two of its status bits are live service requests. They are derived each cycle from the receive and transmit buffer fill levels and from the direction enables, and they also drive the DMA request outputs directly. The other two bits are sticky frame events: transmit frame finished, and transmit frame ended by abort. Software clears each event bit by writing 1 to it.

The framing engine reports how each frame ended with single-cycle pulses. When an abort pulse arrives while the underrun-abort control is on, both event bits are set together. Software reaches the unit through a plain word-indexed register port: index 0 is the status word and index 1 is the mask word. Reads are combinational and writes take effect on the clock edge. The interrupt output is a flop fed by the OR of all masked status bits.

Status word layout: bit 0 is the receive service request, bit 1 the transmit service request, bit 2 frame finished and bit 3 frame aborted. The mask word uses the same bit positions. All higher bits of both words read 0.

Top module: `irf_irq_status`

## Requirements
- R1: Status bit 0 (and `rx_dma_req`) is 1 exactly when `rx_level` is nonzero, `rx_en` is 1 and `rx_discard` is 0, evaluated combinationally in the same cycle.
- R2: Status bit 1 (and `tx_dma_req`) is 1 exactly when `tx_level` is below the transmit depth and `tx_en` is 1.
- R3: A one-cycle pulse on `tx_frame_end` or on `tx_frame_abort` sets status bit 2 at the next clock edge, and the bit stays set until it is cleared.
- R4: A pulse on `tx_frame_abort` sets status bit 3 only while `underrun_abort_en` is 1. In that case bits 2 and 3 are set at the same edge. With the control at 0, only bit 2 is set.
- R5: Writing 1 to bit 2 or bit 3 of the status word clears that bit, and writing 0 leaves it as it is. Writes to bits 0, 1 and to the upper bits have no effect.
- R6: If a set event and a clearing write hit the same event bit in the same cycle, the bit ends up set.
- R7: The mask word at index 1 is read/write over bits 3:0 and resets to 0. Its upper bits, and the upper bits of the status word, read 0.
- R8: `irq` goes to 1 one clock after any status bit whose mask bit is 1 becomes 1, and it falls one clock after no masked status bit remains set.
- R9: After reset the event bits, the mask and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_level | input | LVL_W | Receive buffer fill count |
| rx_en | input | 1 | Receiver enabled |
| rx_discard | input | 1 | Receiver is dropping incoming data |
| tx_level | input | LVL_W | Transmit buffer fill count |
| tx_en | input | 1 | Transmitter enabled |
| underrun_abort_en | input | 1 | Underrun-abort control; lets abort endings be flagged |
| tx_frame_end | input | 1 | One-cycle pulse: frame ended normally |
| tx_frame_abort | input | 1 | One-cycle pulse: frame ended by abort |
| reg_addr | input | ADDR_W | Register word index (0 status, 1 mask) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| rx_dma_req | output | 1 | Receive DMA service request |
| tx_dma_req | output | 1 | Transmit DMA service request |
| irq | output | 1 | Registered masked interrupt |

## Verification
A clearing write from software and a frame event from the framing engine can land on the same event bit in the same cycle. The bench forces this case by raising the write strobe, with a 1 in the bit-2 position, on the same clock as a frame-end pulse. It then reads the status back on the following cycle, and the bit must still be set. A second case pairs an abort pulse with a clear of the aborted bit and applies the same rule.

// File: rtl/irf_irq_pkg.sv
package irf_irq_pkg;
    localparam int NUM_SRC     = 4;
    localparam int BIT_RX_SVC  = 0;
    localparam int BIT_TX_SVC  = 1;
    localparam int BIT_TX_DONE = 2;
    localparam int BIT_TX_ABRT = 3;
    localparam int IDX_STATUS  = 0;
    localparam int IDX_MASK    = 1;

    typedef struct packed {
        logic done;
        logic abrt;
    } evt_flags_t;

    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
        logic               irq;
    } mask_irq_t;
endpackage

// File: rtl/irf_svc_req.sv
module irf_svc_req #(
    parameter int RX_DEPTH = 16,
    parameter int TX_DEPTH = 16,
    localparam int LVL_W   = $clog2((RX_DEPTH > TX_DEPTH ? RX_DEPTH : TX_DEPTH) + 1)
) (
    input  logic [LVL_W-1:0] rx_level_i,
    input  logic             rx_en_i,
    input  logic             rx_discard_i,
    input  logic [LVL_W-1:0] tx_level_i,
    input  logic             tx_en_i,
    output logic             rx_svc_o,
    output logic             tx_svc_o
);
    localparam logic [LVL_W-1:0] TX_FULL = LVL_W'(TX_DEPTH);

    always_comb begin
        // receive side wants service while data waits and the receiver is live
        rx_svc_o = (rx_level_i != '0) && rx_en_i && !rx_discard_i;
        // transmit side wants service while there is room and the sender is live
        tx_svc_o = (tx_level_i < TX_FULL) && tx_en_i;
    end
endmodule

// File: rtl/irf_event_flags.sv
module irf_event_flags
    import irf_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_end_i,
    input  logic frame_abort_i,
    input  logic underrun_en_i,
    input  logic clr_done_i,
    input  logic clr_abrt_i,
    output logic done_o,
    output logic abrt_o
);
    evt_flags_t flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (clr_done_i) flags_d.done = 1'b0;
        if (clr_abrt_i) flags_d.abrt = 1'b0;
        // set after clear: a coincident event wins
        if (frame_end_i || frame_abort_i)     flags_d.done = 1'b1;
        if (frame_abort_i && underrun_en_i)   flags_d.abrt = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign done_o = flags_q.done;
    assign abrt_o = flags_q.abrt;

    p_abort_needs_ctrl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abrt_o) |-> $past(frame_abort_i && underrun_en_i));
    p_abort_marks_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_abort_i |=> done_o);
    p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end_i && clr_done_i) |=> done_o);
    p_done_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clr_done_i) |=> done_o);
endmodule

// File: rtl/irf_mask_irq.sv
module irf_mask_irq
    import irf_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mask_wr_i,
    input  logic [NUM_SRC-1:0] mask_wdata_i,
    input  logic [NUM_SRC-1:0] status_i,
    output logic [NUM_SRC-1:0] mask_o,
    output logic               irq_o
);
    mask_irq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mask_wr_i) st_d.mask = mask_wdata_i;
        st_d.irq = |(status_i & st_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;
    assign irq_o  = st_q.irq;

    p_irq_has_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|status_i));
    p_mask_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr_i |=> $stable(mask_o));
endmodule

// File: rtl/irf_irq_status.sv
module irf_irq_status
    import irf_irq_pkg::*;
#(
    parameter int RX_DEPTH = 16,
    parameter int TX_DEPTH = 16,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 2,
    localparam int LVL_W   = $clog2((RX_DEPTH > TX_DEPTH ? RX_DEPTH : TX_DEPTH) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              rx_en,
    input  logic              rx_discard,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic              tx_en,
    input  logic              underrun_abort_en,
    input  logic              tx_frame_end,
    input  logic              tx_frame_abort,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              rx_dma_req,
    output logic              tx_dma_req,
    output logic              irq
);
    logic               rx_svc, tx_svc, done_f, abrt_f;
    logic               sel_status, sel_mask;
    logic [NUM_SRC-1:0] status_vec, mask_vec;
    logic               wdata_unused;

    assign sel_status   = (reg_addr == ADDR_W'(IDX_STATUS));
    assign sel_mask     = (reg_addr == ADDR_W'(IDX_MASK));
    assign wdata_unused = ^reg_wdata[DATA_W-1:NUM_SRC];

    irf_svc_req #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) i_svc (
        .rx_level_i   (rx_level),
        .rx_en_i      (rx_en),
        .rx_discard_i (rx_discard),
        .tx_level_i   (tx_level),
        .tx_en_i      (tx_en),
        .rx_svc_o     (rx_svc),
        .tx_svc_o     (tx_svc)
    );

    irf_event_flags i_evt (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_end_i   (tx_frame_end),
        .frame_abort_i (tx_frame_abort),
        .underrun_en_i (underrun_abort_en),
        .clr_done_i    (reg_wr && sel_status && reg_wdata[BIT_TX_DONE]),
        .clr_abrt_i    (reg_wr && sel_status && reg_wdata[BIT_TX_ABRT]),
        .done_o        (done_f),
        .abrt_o        (abrt_f)
    );

    always_comb begin
        status_vec              = '0;
        status_vec[BIT_RX_SVC]  = rx_svc;
        status_vec[BIT_TX_SVC]  = tx_svc;
        status_vec[BIT_TX_DONE] = done_f;
        status_vec[BIT_TX_ABRT] = abrt_f;
    end

    irf_mask_irq i_mask (
        .clk          (clk),
        .rst_n        (rst_n),
        .mask_wr_i    (reg_wr && sel_mask),
        .mask_wdata_i (reg_wdata[NUM_SRC-1:0]),
        .status_i     (status_vec),
        .mask_o       (mask_vec),
        .irq_o        (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (sel_status)    reg_rdata[NUM_SRC-1:0] = status_vec;
        else if (sel_mask) reg_rdata[NUM_SRC-1:0] = mask_vec;
    end

    assign rx_dma_req = rx_svc;
    assign tx_dma_req = tx_svc;

    p_rx_req_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_req |-> (rx_en && !rx_discard));
    p_tx_req_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !tx_dma_req);
    p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:NUM_SRC] == '0);
endmodule

// File: tb/test_irf_irq_status.sv
module test_irf_irq_status;
    localparam int LW = 5;
    logic clk = 0, rst_n = 0;
    logic [LW-1:0] rx_level = 0, tx_level = 0;
    logic rx_en = 0, rx_discard = 0, tx_en = 0, underrun_abort_en = 0;
    logic tx_frame_end = 0, tx_frame_abort = 0, reg_wr = 0;
    logic [1:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic rx_dma_req, tx_dma_req, irq;
    int n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    irf_irq_status i_irf_irq_status (.*);

    // rx_level, rx_en, rx_discard, tx_level, tx_en, exp_rx, exp_tx
    localparam logic [14:0] VEC [0:7] = '{
        {5'd0,  1'b1, 1'b0, 5'd16, 1'b1, 1'b0, 1'b0},
        {5'd1,  1'b1, 1'b0, 5'd16, 1'b1, 1'b1, 1'b0},
        {5'd9,  1'b0, 1'b0, 5'd15, 1'b1, 1'b0, 1'b1},
        {5'd9,  1'b1, 1'b1, 5'd0,  1'b0, 1'b0, 1'b0},
        {5'd16, 1'b1, 1'b0, 5'd0,  1'b1, 1'b1, 1'b1},
        {5'd3,  1'b1, 1'b1, 5'd3,  1'b1, 1'b0, 1'b1},
        {5'd0,  1'b0, 1'b0, 5'd16, 1'b0, 1'b0, 1'b0},
        {5'd2,  1'b1, 1'b0, 5'd7,  1'b0, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk); reg_wr = 0; reg_wdata = 0;
    endtask

    task automatic pulse(input logic fe, input logic fa);
        tx_frame_end = fe; tx_frame_abort = fa;
        @(negedge clk); tx_frame_end = 0; tx_frame_abort = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        rd(0, d); chk("R9 status after reset", d, 32'h0);
        rd(1, d); chk("R9 mask after reset", d, 32'h0);
        chk("R9 irq after reset", {31'b0, irq}, 32'h0);

        wr(1, 32'hFFFF_FFFF);
        rd(1, d); chk("R7 mask readback, reserved zero", d, 32'hF);

        foreach (VEC[i]) begin
            {rx_level, rx_en, rx_discard, tx_level, tx_en} = VEC[i][14:2];
            rd(0, d);
            chk($sformatf("R1 rx svc vec%0d", i), {31'b0, d[0]}, {31'b0, VEC[i][1]});
            chk($sformatf("R2 tx svc vec%0d", i), {31'b0, d[1]}, {31'b0, VEC[i][0]});
            chk($sformatf("R1 R2 dma vec%0d", i), {30'b0, rx_dma_req, tx_dma_req}, {30'b0, VEC[i][1:0]});
            @(negedge clk);
            chk($sformatf("R8 irq vec%0d", i), {31'b0, irq}, {31'b0, |VEC[i][1:0]});
        end

        // latency: source rises, irq follows one edge later
        rx_en = 0; tx_en = 0; @(negedge clk);
        rx_level = 4; rx_en = 1; #1;
        chk("R8 irq not yet", {31'b0, irq}, 0);
        @(negedge clk);
        chk("R8 irq after one edge", {31'b0, irq}, 1);
        rx_en = 0;
        wr(1, 0);
        @(negedge clk);

        pulse(1, 0);
        rd(0, d); chk("R3 frame end sets done only", d, 32'h4);
        chk("R8 masked off keeps irq low", {31'b0, irq}, 0);
        repeat (3) @(negedge clk);
        rd(0, d); chk("R3 done sticky", d, 32'h4);
        wr(0, 32'h0);
        rd(0, d); chk("R5 write zero keeps", d, 32'h4);
        wr(0, 32'hFFFF_FFF3);
        rd(0, d); chk("R5 svc and upper writes ignored", d, 32'h4);
        wr(0, 32'h4);
        rd(0, d); chk("R5 w1c clears done", d, 32'h0);

        underrun_abort_en = 0;
        pulse(0, 1);
        rd(0, d); chk("R4 abort without control", d, 32'h4);
        wr(0, 32'h4);
        underrun_abort_en = 1;
        pulse(0, 1);
        rd(0, d); chk("R4 abort with control sets both", d, 32'hC);

        // coincident clear and set on done
        reg_addr = 0; reg_wdata = 32'h4; reg_wr = 1; tx_frame_end = 1;
        @(negedge clk); reg_wr = 0; tx_frame_end = 0;
        rd(0, d); chk("R6 set wins over clear", d, 32'hC);
        // coincident clear and set on aborted
        reg_addr = 0; reg_wdata = 32'h8; reg_wr = 1; tx_frame_abort = 1;
        @(negedge clk); reg_wr = 0; tx_frame_abort = 0;
        rd(0, d); chk("R6 abort set wins", d, 32'hC);
        wr(0, 32'h4);
        rd(0, d); chk("R5 clear one keeps other", d, 32'h8);

        wr(1, 32'h8);
        chk("R8 irq one edge after mask", {31'b0, irq}, 0);
        @(negedge clk);
        chk("R8 irq raised", {31'b0, irq}, 1);
        wr(0, 32'h8);
        chk("R8 irq still high at clear edge", {31'b0, irq}, 1);
        @(negedge clk);
        chk("R8 irq falls", {31'b0, irq}, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule